// File: doc/BRIEF.md
# Privileged Control Register File

This block holds a small set of privileged 64-bit control registers behind one index-addressed access port. Each cycle the port may carry a single read or a single write. A read returns its data one cycle later. A write updates the selected register at the clock edge. Several registers change the data on its way in or out, and some accesses raise events.

The software-interrupt pending register has three write addresses. The direct address replaces the whole value. The set alias ORs the written data into the current value. The clear alias removes the bits that are ones in the written data.

- The trap-base register always keeps its low fifteen bits at zero.
- Every write to the hypervisor state register forces bit 11 on.
- The version word is a constant assembled from parameters, and it can only be read.
- Eight queue pointer registers, a head and a tail for each of four queues, are plain storage. A write to any of them asks the core to re-examine pending interrupts.
- A raise of the software-interrupt level asks for the same re-examination.
- Any access the map does not allow raises an error and changes nothing.

Top module: `priv_ctl_regfile`

## Requirements
- R1: After reset every storage register reads as zero, and `acc_err` and `irq_recheck` are low.
- R2: A write to index 0 stores the data in the software-interrupt pending register. A read of index 0 returns that value.
- R3: A write to index 1, the set alias, makes the pending value equal to the old value OR the written data.
- R4: A write to index 2, the clear alias, makes the pending value equal to the old value AND the inverse of the written data.
- R5: The trap-base register (index 4) stores written data with bits 14:0 forced to zero, and reads of it return bits 14:0 as zero.
- R6: Every write to the hypervisor state register (index 5) stores the data with bit 11 set.
- R7: A read of index 7 returns the window count in bits 7:0, the maximum trap level in bits 15:8 and the maximum global level in bits 23:16. All other bits read as zero. A write to index 7 is illegal.
- R8: An illegal access sets `acc_err` in the following cycle, changes no register and returns zero read data. Illegal accesses are a write to index 7, a read of index 1 or 2, and any access to index 16 or above.
- R9: Indices 8 to 15 are queue pointer registers (queue k head at 8+2k, tail at 9+2k). A write stores the data and pulses `irq_recheck` high for exactly the following cycle.
- R10: The pending level is 1 plus the position of the highest set bit among pending bits 15:0, or 0 if none of them is set. A write through index 0, 1 or 2 pulses `irq_recheck` in the following cycle only if the new level is greater than the old level.
- R11: The interrupt level register (index 3) and the hypervisor trap state register (index 6) store and return all 64 bits unchanged.
- R12: `rd_data` shows the value of a legal read in the cycle after the request. Writes do not change `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_index | input | 5 | Register index |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data, one cycle after the request |
| acc_err | output | 1 | Illegal-access flag, one cycle after the request |
| irq_recheck | output | 1 | One-cycle request to re-examine interrupts |

## Verification
There are two ways to produce `irq_recheck`: a queue pointer write and a rise in the software-interrupt level. The error path must also keep `irq_recheck` low. The bench issues a level-raising pending write in the cycle directly after a queue write, and a queue write directly after a pending write that does not raise the level. It then checks, cycle by cycle, that each pulse belongs to the access before it and not to a neighbour. The bench also follows illegal accesses at once with reads of the registers they might have touched.

// File: rtl/privreg_pkg.sv
package privreg_pkg;

  localparam int DATA_W   = 64;
  localparam int IDX_W    = 5;
  localparam int LVL_BITS = 16;
  localparam int LVL_W    = 5;
  localparam int QCOUNT   = 8;
  localparam int QSEL_W   = $clog2(QCOUNT);
  localparam int TB_ZERO  = 15;
  localparam int HS_FORCE = 11;

  localparam logic [IDX_W-1:0] IX_SWINT   = 5'd0;
  localparam logic [IDX_W-1:0] IX_SWSET   = 5'd1;
  localparam logic [IDX_W-1:0] IX_SWCLR   = 5'd2;
  localparam logic [IDX_W-1:0] IX_PRILVL  = 5'd3;
  localparam logic [IDX_W-1:0] IX_TBASE   = 5'd4;
  localparam logic [IDX_W-1:0] IX_HSTATE  = 5'd5;
  localparam logic [IDX_W-1:0] IX_HTRAP   = 5'd6;
  localparam logic [IDX_W-1:0] IX_VERSION = 5'd7;
  localparam logic [IDX_W-1:0] IX_QBASE   = 5'd8;

  typedef enum logic [1:0] {SW_DIRECT, SW_SET, SW_CLEAR} sw_mode_e;

  typedef struct packed {
    logic              sw_any;
    sw_mode_e          sw_mode;
    logic              prilvl;
    logic              tbase;
    logic              hstate;
    logic              htrap;
    logic              version;
    logic              queue;
    logic [QSEL_W-1:0] qsel;
  } acc_sel_t;

  // Level: 1 + highest set bit among the low LVL_BITS, 0 when none is set.
  function automatic logic [LVL_W-1:0] pend_level(input logic [DATA_W-1:0] v);
    logic [LVL_W-1:0] lvl;
    lvl = '0;
    for (int i = 0; i < LVL_BITS; i++)
      if (v[i]) lvl = LVL_W'(i + 1);
    return lvl;
  endfunction

  function automatic logic [DATA_W-1:0] sw_next(input logic [DATA_W-1:0] cur,
                                                input logic [DATA_W-1:0] d,
                                                input sw_mode_e m);
    case (m)
      SW_SET:   return cur | d;
      SW_CLEAR: return cur & ~d;
      default:  return d;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] tbase_clean(input logic [DATA_W-1:0] d);
    return {d[DATA_W-1:TB_ZERO], {TB_ZERO{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] hstate_force(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    r[HS_FORCE] = 1'b1;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] version_word(input logic [7:0] nwin,
                                                     input logic [7:0] maxtl,
                                                     input logic [7:0] maxgl);
    return {{(DATA_W-24){1'b0}}, maxgl, maxtl, nwin};
  endfunction

endpackage

// File: rtl/privreg_decode.sv
module privreg_decode
  import privreg_pkg::*;
(
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_index,
  output acc_sel_t         sel,
  output logic             legal
);
  logic in_queue;
  assign in_queue = (acc_index >= IX_QBASE) && (acc_index < IX_QBASE + IDX_W'(QCOUNT));

  always_comb begin
    sel = '0;
    sel.sw_mode = SW_DIRECT;
    sel.qsel = QSEL_W'(acc_index - IX_QBASE);
    case (acc_index)
      IX_SWINT:   sel.sw_any = 1'b1;
      IX_SWSET:   begin sel.sw_any = 1'b1; sel.sw_mode = SW_SET; end
      IX_SWCLR:   begin sel.sw_any = 1'b1; sel.sw_mode = SW_CLEAR; end
      IX_PRILVL:  sel.prilvl  = 1'b1;
      IX_TBASE:   sel.tbase   = 1'b1;
      IX_HSTATE:  sel.hstate  = 1'b1;
      IX_HTRAP:   sel.htrap   = 1'b1;
      IX_VERSION: sel.version = 1'b1;
      default:    sel.queue   = in_queue;
    endcase
  end

  always_comb begin
    if (acc_write)
      legal = sel.sw_any | sel.prilvl | sel.tbase | sel.hstate | sel.htrap | sel.queue;
    else
      legal = (sel.sw_any && sel.sw_mode == SW_DIRECT) | sel.prilvl | sel.tbase |
              sel.hstate | sel.htrap | sel.version | sel.queue;
  end
endmodule

// File: rtl/privreg_softint.sv
module privreg_softint
  import privreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  sw_mode_e          mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] pend_q,
  output logic              level_rise
);
  logic [DATA_W-1:0] pend_d;

  assign pend_d     = sw_next(pend_q, wdata, mode);
  assign level_rise = we && (pend_level(pend_d) > pend_level(pend_q));

  always_ff @(posedge clk) begin
    if (!rst_n)  pend_q <= '0;
    else if (we) pend_q <= pend_d;
  end
endmodule

// File: rtl/privreg_qbank.sv
module privreg_qbank
  import privreg_pkg::*;
#(
  parameter int NQ = QCOUNT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [$clog2(NQ)-1:0]  wsel,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [$clog2(NQ)-1:0]  rsel,
  output logic [DATA_W-1:0]      rdata
);
  localparam int SW = $clog2(NQ);
  logic [DATA_W-1:0] qreg [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    always_ff @(posedge clk) begin
      if (!rst_n) qreg[g] <= '0;
      else if (we && wsel == SW'(g)) qreg[g] <= wdata;
    end
  end

  assign rdata = qreg[rsel];
endmodule

// File: rtl/priv_ctl_regfile.sv
module priv_ctl_regfile
  import privreg_pkg::*;
#(
  parameter logic [7:0] NWIN  = 8'd8,
  parameter logic [7:0] MAXTL = 8'd6,
  parameter logic [7:0] MAXGL = 8'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [IDX_W-1:0]  acc_index,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err,
  output logic              irq_recheck
);
  localparam logic [DATA_W-1:0] VER_WORD = version_word(NWIN, MAXTL, MAXGL);

  acc_sel_t          sel;
  logic              legal;
  logic              wr_ok, rd_ok, illegal, q_wr, sw_wr, sw_rise;
  logic [DATA_W-1:0] pend_q, prilvl_q, tbase_q, hstate_q, htrap_q, q_rdata;
  logic [DATA_W-1:0] rd_mux;

  privreg_decode u_dec (
    .acc_write (acc_write),
    .acc_index (acc_index),
    .sel       (sel),
    .legal     (legal)
  );

  assign wr_ok   = acc_valid &&  acc_write && legal;
  assign rd_ok   = acc_valid && !acc_write && legal;
  assign illegal = acc_valid && !legal;
  assign sw_wr   = wr_ok && sel.sw_any;
  assign q_wr    = wr_ok && sel.queue;

  privreg_softint u_sw (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (sw_wr),
    .mode       (sel.sw_mode),
    .wdata      (wr_data),
    .pend_q     (pend_q),
    .level_rise (sw_rise)
  );

  privreg_qbank #(.NQ(QCOUNT)) u_qb (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (q_wr),
    .wsel  (sel.qsel),
    .wdata (wr_data),
    .rsel  (sel.qsel),
    .rdata (q_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prilvl_q <= '0;
      tbase_q  <= '0;
      hstate_q <= '0;
      htrap_q  <= '0;
    end else if (wr_ok) begin
      if (sel.prilvl) prilvl_q <= wr_data;
      if (sel.tbase)  tbase_q  <= tbase_clean(wr_data);
      if (sel.hstate) hstate_q <= hstate_force(wr_data);
      if (sel.htrap)  htrap_q  <= wr_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel.sw_any)  rd_mux = pend_q;
    if (sel.prilvl)  rd_mux = prilvl_q;
    if (sel.tbase)   rd_mux = tbase_clean(tbase_q);
    if (sel.hstate)  rd_mux = hstate_q;
    if (sel.htrap)   rd_mux = htrap_q;
    if (sel.version) rd_mux = VER_WORD;
    if (sel.queue)   rd_mux = q_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data     <= '0;
      acc_err     <= 1'b0;
      irq_recheck <= 1'b0;
    end else begin
      acc_err     <= illegal;
      irq_recheck <= q_wr | sw_rise;
      if (rd_ok)                       rd_data <= rd_mux;
      else if (illegal && !acc_write)  rd_data <= '0;
    end
  end
endmodule

// File: rtl/priv_ctl_chk.sv
module priv_ctl_chk
  import privreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [IDX_W-1:0]  acc_index,
  input logic [DATA_W-1:0] wr_data,
  input logic              acc_err,
  input logic              irq_recheck,
  input logic [DATA_W-1:0] pend_q,
  input logic [DATA_W-1:0] tbase_q,
  input logic [DATA_W-1:0] hstate_q
);
  logic wr_go;
  assign wr_go = acc_valid && acc_write;

  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && acc_index == IX_SWSET |=> pend_q == ($past(pend_q) | $past(wr_data)));

  p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && acc_index == IX_SWCLR |=> pend_q == ($past(pend_q) & ~$past(wr_data)));

  p_tbase_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tbase_q[TB_ZERO-1:0] == '0);

  p_hstate_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && acc_index == IX_HSTATE |=> hstate_q[HS_FORCE]);

  p_version_write_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && acc_index == IX_VERSION |=> acc_err);

  p_unmapped_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_index >= IX_QBASE + IDX_W'(QCOUNT) |=> acc_err && $stable(pend_q));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !irq_recheck);

  p_queue_recheck_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && acc_index >= IX_QBASE && acc_index < IX_QBASE + IDX_W'(QCOUNT) |=> irq_recheck);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !irq_recheck && !acc_err);
endmodule

bind priv_ctl_regfile priv_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_index   (acc_index),
  .wr_data     (wr_data),
  .acc_err     (acc_err),
  .irq_recheck (irq_recheck),
  .pend_q      (pend_q),
  .tbase_q     (tbase_q),
  .hstate_q    (hstate_q)
);

// File: tb/priv_ctl_regfile_tb.sv
module priv_ctl_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [4:0]  acc_index = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        acc_err;
  logic        irq_recheck;

  localparam logic [63:0] VER_EXP = 64'h0000_0000_0003_0608;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  priv_ctl_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_index(acc_index), .wr_data(wr_data), .rd_data(rd_data),
    .acc_err(acc_err), .irq_recheck(irq_recheck)
  );

  // Expected item: {check_rd, rd, err, recheck}
  logic [66:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_rd = '0;

  // Shadow state
  logic [63:0] m_sw = 0, m_pil = 0, m_tb = 0, m_hs = 0, m_ht = 0;
  logic [63:0] m_q [8];

  function automatic int lvl(input logic [63:0] v);
    for (int i = 15; i >= 0; i--) if (v[i]) return i + 1;
    return 0;
  endfunction

  task automatic acc(input bit w, input int idx, input logic [63:0] d, input string tag);
    logic [63:0] rv;
    logic [63:0] nsw;
    bit e, rc;
    rv = last_rd; e = 0; rc = 0;
    if (w) begin
      case (idx)
        0, 1, 2: begin
          nsw = (idx == 0) ? d : (idx == 1) ? (m_sw | d) : (m_sw & ~d);
          rc = lvl(nsw) > lvl(m_sw);
          m_sw = nsw;
        end
        3: m_pil = d;
        4: m_tb = d & ~64'h7FFF;
        5: m_hs = d | 64'h800;
        6: m_ht = d;
        default: if (idx >= 8 && idx < 16) begin m_q[idx-8] = d; rc = 1; end
                 else e = 1;
      endcase
    end else begin
      case (idx)
        0: rv = m_sw;
        3: rv = m_pil;
        4: rv = m_tb;
        5: rv = m_hs;
        6: rv = m_ht;
        7: rv = VER_EXP;
        default: if (idx >= 8 && idx < 16) rv = m_q[idx-8];
                 else begin e = 1; rv = 0; end
      endcase
    end
    last_rd = rv;
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_index = 5'(idx); wr_data = d;
    exp_q.push_back({1'b1, rv, e, rc});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 0; acc_write = 0;
    end
  endtask

  // Monitor: one expected item per access, checked after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && exp_q.size() > 0) begin
        logic [66:0] it;
        string t;
        it = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if (rd_data !== it[65:2] || acc_err !== it[1] || irq_recheck !== it[0]) begin
          n_fail++;
          $display("FAIL %s: rd=%h err=%b rchk=%b expected rd=%h err=%b rchk=%b",
                   t, rd_data, acc_err, irq_recheck, it[65:2], it[1], it[0]);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_q[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_tests++;
    if (acc_err !== 0 || irq_recheck !== 0 || rd_data !== 0) begin
      n_fail++;
      $display("FAIL R1: err=%b rchk=%b rd=%h expected 0 0 0", acc_err, irq_recheck, rd_data);
    end
    // R1: reset values
    acc(0, 0, 0, "R1 swint"); acc(0, 3, 0, "R1 pil"); acc(0, 4, 0, "R1 tbase");
    acc(0, 5, 0, "R1 hstate"); acc(0, 6, 0, "R1 htrap");
    for (int i = 8; i < 16; i++) acc(0, i, 0, "R1 queue");
    // R7 version
    acc(0, 7, 0, "R7 version read");
    // R2 / R10
    acc(1, 0, 64'h5, "R10 direct raise");
    acc(0, 0, 0, "R2 readback");
    // R3 set alias
    acc(1, 1, 64'h100, "R3 set raise");
    acc(1, 1, 64'h2, "R10 set no raise");
    acc(0, 0, 0, "R3 readback");
    // R4 clear alias
    acc(1, 2, 64'h104, "R4 clear");
    acc(0, 0, 0, "R4 readback");
    acc(1, 0, 64'hFFFF_0000_0000_0001, "R10 direct lower");
    acc(1, 0, 64'h8000, "R10 direct top level");
    acc(1, 1, 64'hF000_0000_0000_0000, "R10 set high bits only");
    acc(0, 0, 0, "R2 readback high");
    // R5
    acc(1, 4, 64'hFFFF_FFFF_FFFF_FFFF, "R5 tbase write");
    acc(0, 4, 0, "R5 tbase read");
    acc(1, 4, 64'h0000_0000_0001_7FFF, "R5 tbase write2");
    acc(0, 4, 0, "R5 tbase read2");
    // R6
    acc(1, 5, 64'h0, "R6 hstate zero");
    acc(0, 5, 0, "R6 read");
    acc(1, 5, 64'h1234, "R6 hstate data");
    acc(0, 5, 0, "R6 read2");
    // R11
    acc(1, 3, 64'hDEAD_BEEF_0123_4567, "R11 pil");
    acc(1, 6, 64'hA5A5_5A5A_FFFF_0000, "R11 htrap");
    acc(0, 3, 0, "R11 pil read"); acc(0, 6, 0, "R11 htrap read");
    // R7 / R8 illegal
    acc(1, 7, 64'hFFFF, "R7 version write");
    acc(0, 7, 0, "R7 version unchanged");
    acc(1, 20, 64'hFFFF, "R8 unmapped write");
    acc(0, 0, 0, "R8 swint untouched");
    acc(0, 31, 0, "R8 unmapped read");
    acc(0, 1, 0, "R8 set alias read");
    acc(0, 2, 0, "R8 clear alias read");
    acc(0, 16, 0, "R8 index 16 read");
    acc(0, 5, 0, "R8 hstate untouched");
    // R9 queue writes, back to back, then mixed with softint
    for (int i = 8; i < 16; i++) acc(1, i, 64'h1000 + 64'(i), "R9 queue write");
    for (int i = 8; i < 16; i++) acc(0, i, 0, "R9 queue read");
    acc(1, 0, 64'h0, "R10 clear all");
    acc(1, 9, 64'h77, "R9 queue then raise");
    acc(1, 1, 64'h4, "R10 raise after queue");
    acc(1, 1, 64'h1, "R10 no raise");
    acc(1, 12, 64'h88, "R9 queue after no raise");
    acc(0, 12, 0, "R12 read after write");
    acc(1, 3, 64'h1, "R12 write keeps rd");
    idle(1);
    acc(0, 0, 0, "R12 final read");
    idle(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule